// File: doc/BRIEF.md
# Four-Lane Halfword Saturating Arithmetic Unit

This block is a packed-SIMD execution unit for a datapath that handles 16-bit quantities four at a time. Each of the two 64-bit operands is cut into four 16-bit lanes. One operation, chosen by a 3-bit code, is applied to every lane pair at once. Each lane produces its own 16-bit result, and no carry, borrow or shifted bit crosses from one lane into the next.

Seven operations are available. Add and subtract come in two flavours. The signed flavour clamps to the two's-complement halfword range. The mixed flavour reads the first operand as unsigned and the second as signed, and clamps to the unsigned halfword range. An unsigned average rounds by folding the dropped bit into the result's lowest bit. Two scaled adds shift the first operand's lane left, or arithmetically right, by 0 to 3 places before adding the second lane, and saturate to the signed range. Each lane's exact result is formed at 20 bits, so nothing wraps before the clamp.

The unit registers its result. A request presented with `in_valid` appears on `out_data` with `out_valid` on the next clock edge. The result register holds its value until the next request.

Top module: `hw_sat_simd`

## Requirements
- R1: Lane k (k = 0..3) occupies bits [16k+15:16k] of both operands and of the result. A lane's result depends only on that lane's operand bits, so a saturating or carrying lane leaves its neighbours unchanged.
- R2: Code 0 (signed add) sign-extends both lanes, adds them, and clamps the sum to -32768..32767.
- R3: Code 1 (signed subtract) sign-extends both lanes, computes first minus second, and clamps to -32768..32767.
- R4: Code 2 (mixed add) zero-extends the first lane, sign-extends the second, adds them, and clamps to 0..65535.
- R5: Code 3 (mixed subtract) zero-extends the first lane, sign-extends the second, computes first minus second, and clamps to 0..65535.
- R6: Code 4 (average) forms the 17-bit unsigned sum of the lanes. The result is the sum shifted right by one place, ORed with the sum's bit 0.
- R7: Code 5 (scaled add, left) shifts the signed first lane left by `shamt` (0..3), adds the signed second lane, and clamps to -32768..32767.
- R8: Code 6 (scaled add, right) shifts the signed first lane arithmetically right by `shamt` (0..3), adds the signed second lane, and clamps to -32768..32767.
- R9: Code 7 is unassigned and yields an all-zero result.
- R10: `out_valid` equals `in_valid` delayed by exactly one clock. `out_data` changes only on an edge where `in_valid` is high, and holds otherwise.
- R11: While `rst` is high at a clock edge, `out_valid` and `out_data` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands, code and shift are sampled when high |
| op_sel | input | 3 | Operation code (0..6 as listed, 7 unassigned) |
| shamt | input | 2 | Shift amount for codes 5 and 6 |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| out_valid | output | 1 | High for one cycle per request, one clock after it |
| out_data | output | 64 | Registered packed result |

## Verification
Every result is due exactly one rising edge after the edge that samples its request. The driver applies the stimulus just after a falling edge and enqueues the value computed by an integer reference model. The monitor works on the following falling edge: if `out_valid` is set there, it pops the oldest expected entry and compares it to `out_data`. The monitor also checks `out_valid` at every falling edge against `in_valid` captured one edge earlier. On idle cycles it checks that `out_data` still equals the last delivered result, which covers both the one-cycle latency and the hold behaviour.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic [2:0] {
    OP_ADD_SS  = 3'd0,
    OP_SUB_SS  = 3'd1,
    OP_ADD_US  = 3'd2,
    OP_SUB_US  = 3'd3,
    OP_AVG     = 3'd4,
    OP_SHL_ADD = 3'd5,
    OP_SHR_ADD = 3'd6,
    OP_NONE    = 3'd7
  } hws_op_e;

  typedef enum logic [1:0] {
    CL_SIGNED   = 2'd0,
    CL_UNSIGNED = 2'd1,
    CL_PASS     = 2'd2,
    CL_ZERO     = 2'd3
  } hws_clamp_e;

endpackage

// File: rtl/hws_lane_arith.sv
module hws_lane_arith
  import hws_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int SH_W   = 2,
  localparam int EXT_W = LANE_W + (2 ** SH_W)
) (
  input  hws_op_e                  op,
  input  logic [LANE_W-1:0]        a,
  input  logic [LANE_W-1:0]        b,
  input  logic [SH_W-1:0]          sh,
  output logic signed [EXT_W-1:0]  exact,
  output hws_clamp_e               mode
);

  localparam int PAD = EXT_W - LANE_W;

  logic signed [EXT_W-1:0] a_s, a_u, b_s, b_u;
  logic signed [EXT_W-1:0] a_shl, a_shr;
  logic signed [EXT_W-1:0] avg_sum, avg_val;

  // Extend each lane once; every operation selects the extension it needs.
  always_comb begin
    a_s = {{PAD{a[LANE_W-1]}}, a};
    a_u = {{PAD{1'b0}}, a};
    b_s = {{PAD{b[LANE_W-1]}}, b};
    b_u = {{PAD{1'b0}}, b};
  end

  // Scaled first operand; the wide result means the left shift cannot lose bits.
  always_comb begin
    a_shl = a_s <<< sh;
    a_shr = a_s >>> sh;
  end

  // Sticky-rounded average: the bit shifted out is ORed into the LSB.
  always_comb begin
    avg_sum = a_u + b_u;
    avg_val = (avg_sum >>> 1) | EXT_W'(avg_sum[0]);
  end

  always_comb begin
    exact = '0;
    mode  = CL_ZERO;
    unique case (op)
      OP_ADD_SS: begin
        exact = a_s + b_s;
        mode  = CL_SIGNED;
      end
      OP_SUB_SS: begin
        exact = a_s - b_s;
        mode  = CL_SIGNED;
      end
      OP_ADD_US: begin
        exact = a_u + b_s;
        mode  = CL_UNSIGNED;
      end
      OP_SUB_US: begin
        exact = a_u - b_s;
        mode  = CL_UNSIGNED;
      end
      OP_AVG: begin
        exact = avg_val;
        mode  = CL_PASS;
      end
      OP_SHL_ADD: begin
        exact = a_shl + b_s;
        mode  = CL_SIGNED;
      end
      OP_SHR_ADD: begin
        exact = a_shr + b_s;
        mode  = CL_SIGNED;
      end
      default: begin
        exact = '0;
        mode  = CL_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/hws_lane_clamp.sv
module hws_lane_clamp
  import hws_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int EXT_W  = 20
) (
  input  logic signed [EXT_W-1:0] exact,
  input  hws_clamp_e              mode,
  output logic [LANE_W-1:0]       res
);

  localparam logic signed [EXT_W-1:0] S_MAX = EXT_W'((2 ** (LANE_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] S_MIN = -EXT_W'(2 ** (LANE_W - 1));
  localparam logic signed [EXT_W-1:0] U_MAX = EXT_W'((2 ** LANE_W) - 1);
  localparam logic signed [EXT_W-1:0] U_MIN = '0;

  logic s_hi, s_lo, u_hi, u_lo;

  always_comb begin
    s_hi = exact > S_MAX;
    s_lo = exact < S_MIN;
    u_hi = exact > U_MAX;
    u_lo = exact < U_MIN;
  end

  always_comb begin
    res = exact[LANE_W-1:0];
    unique case (mode)
      CL_SIGNED: begin
        if (s_hi)      res = S_MAX[LANE_W-1:0];
        else if (s_lo) res = S_MIN[LANE_W-1:0];
      end
      CL_UNSIGNED: begin
        if (u_hi)      res = U_MAX[LANE_W-1:0];
        else if (u_lo) res = U_MIN[LANE_W-1:0];
      end
      CL_PASS: res = exact[LANE_W-1:0];
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/hws_lane.sv
module hws_lane
  import hws_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int SH_W   = 2
) (
  input  hws_op_e           op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [SH_W-1:0]   sh,
  output logic [LANE_W-1:0] res
);

  localparam int EXT_W = LANE_W + (2 ** SH_W);

  logic signed [EXT_W-1:0] exact;
  hws_clamp_e              mode;

  hws_lane_arith #(
    .LANE_W (LANE_W),
    .SH_W   (SH_W)
  ) u_arith (
    .op    (op),
    .a     (a),
    .b     (b),
    .sh    (sh),
    .exact (exact),
    .mode  (mode)
  );

  hws_lane_clamp #(
    .LANE_W (LANE_W),
    .EXT_W  (EXT_W)
  ) u_clamp (
    .exact (exact),
    .mode  (mode),
    .res   (res)
  );

endmodule

// File: rtl/hw_sat_simd.sv
module hw_sat_simd
  import hws_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int SH_W   = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  hws_op_e           op;
  logic [DATA_W-1:0] lane_res;

  assign op = hws_op_e'(op_sel);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hws_lane #(
      .LANE_W (LANE_W),
      .SH_W   (SH_W)
    ) u_lane (
      .op  (op),
      .a   (op_a[g*LANE_W +: LANE_W]),
      .b   (op_b[g*LANE_W +: LANE_W]),
      .sh  (shamt),
      .res (lane_res[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= lane_res;
    end
  end

endmodule

// File: rtl/hws_checker.sv
module hws_checker #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd7) |=> out_data == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // Two non-negative lanes never add to a negative signed result.
    assert_add_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 3'd0 && !op_a[g*LANE_W+LANE_W-1] && !op_b[g*LANE_W+LANE_W-1])
      |=> !out_data[g*LANE_W+LANE_W-1]);

    // Zero minus a non-negative lane is floored at zero.
    assert_sub_floor_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 3'd3 && op_a[g*LANE_W +: LANE_W] == '0 && !op_b[g*LANE_W+LANE_W-1])
      |=> out_data[g*LANE_W +: LANE_W] == '0);

    // The average of two equal lanes is that lane.
    assert_avg_equal_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 3'd4 && op_a[g*LANE_W +: LANE_W] == op_b[g*LANE_W +: LANE_W])
      |=> out_data[g*LANE_W +: LANE_W] == $past(op_a[g*LANE_W +: LANE_W]));
  end

endmodule

bind hw_sat_simd hws_checker #(
  .LANE_W (LANE_W),
  .LANES  (LANES)
) u_hws_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/hw_sat_simd_bench.sv
module hw_sat_simd_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANE_W = 16;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [2:0]        op_sel = '0;
  logic [1:0]        shamt = '0;
  logic [DATA_W-1:0] op_a = '0;
  logic [DATA_W-1:0] op_b = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] value;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  logic [DATA_W-1:0] last_data = '0;
  logic prev_in_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_sat_simd u_hw_sat_simd (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .shamt     (shamt),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic int clamp(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic [15:0] ref_lane(logic [2:0] op, logic [15:0] a,
                                           logic [15:0] b, logic [1:0] sh);
    int sa, ua, sb, ub, r;
    sa = int'($signed(a));
    sb = int'($signed(b));
    ua = int'({16'd0, a});
    ub = int'({16'd0, b});
    case (op)
      3'd0: r = clamp(sa + sb, -32768, 32767);
      3'd1: r = clamp(sa - sb, -32768, 32767);
      3'd2: r = clamp(ua + sb, 0, 65535);
      3'd3: r = clamp(ua - sb, 0, 65535);
      3'd4: begin r = ua + ub; r = (r >> 1) | (r & 1); end
      3'd5: r = clamp((sa * (1 << sh)) + sb, -32768, 32767);
      3'd6: r = clamp((sa >>> sh) + sb, -32768, 32767);
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic logic [DATA_W-1:0] ref_word(logic [2:0] op, logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b, logic [1:0] sh);
    logic [DATA_W-1:0] w;
    for (int k = 0; k < LANES; k++)
      w[k*LANE_W +: LANE_W] = ref_lane(op, a[k*LANE_W +: LANE_W], b[k*LANE_W +: LANE_W], sh);
    return w;
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Driver: apply one request after a falling edge and enqueue its expected result.
  task automatic send(logic [2:0] op, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                      logic [1:0] sh, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    op_sel = op;
    op_a = a;
    op_b = b;
    shamt = sh;
    e.value = ref_word(op, a, b, sh);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = $urandom();
      op_b = $urandom();
    end
  endtask

  always @(posedge clk) prev_in_valid <= rst ? 1'b0 : in_valid;

  // Monitor: results are due one edge after the request, seen at the next falling edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (out_valid !== prev_in_valid) begin
        errors++;
        $display("FAIL R10 out_valid latency: actual=%b expected=%b", out_valid, prev_in_valid);
      end
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result: actual=%h expected=none", out_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (out_data !== e.value) begin
            errors++;
            $display("FAIL %s result: actual=%h expected=%h", e.tag, out_data, e.value);
          end
          last_data = e.value;
        end
      end else begin
        checks++;
        if (out_data !== last_data) begin
          errors++;
          $display("FAIL R10 hold: actual=%h expected=%h", out_data, last_data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset clears outputs (checked while reset is still high).
    op_a = '1;
    op_b = '1;
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R11 reset state: actual=%b/%h expected=0/0", out_valid, out_data);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // R2 signed add corners: positive clip, negative clip, plain, zero.
    send(3'd0, {16'h7FFF, 16'h8000, 16'h1234, 16'h0000},
               {16'h0001, 16'hFFFF, 16'h0001, 16'h0000}, 2'd0, "R2");
    // R3 signed subtract corners.
    send(3'd1, {16'h8000, 16'h7FFF, 16'h0005, 16'hFFFF},
               {16'h0001, 16'hFFFF, 16'h0007, 16'h8000}, 2'd0, "R3");
    // R4 mixed add: top clip, floor, pass, large unsigned first lane.
    send(3'd2, {16'hFFFF, 16'h0001, 16'h1000, 16'h8000},
               {16'h0001, 16'hFFFE, 16'hFFFF, 16'h7FFF}, 2'd0, "R4");
    // R5 mixed subtract.
    send(3'd3, {16'h0000, 16'hFFFF, 16'h8000, 16'h0010},
               {16'h0001, 16'hFFFF, 16'h8000, 16'h0004}, 2'd0, "R5");
    // R6 average: odd sum sticky bit, full-scale, even sum.
    send(3'd4, {16'h0003, 16'hFFFF, 16'h0002, 16'h8000},
               {16'h0004, 16'hFFFF, 16'h0004, 16'h8001}, 2'd0, "R6");
    idle(2);
    // R7 shift-left add for each shift amount.
    for (int s = 0; s < 4; s++)
      send(3'd5, {16'h1000, 16'hC000, 16'h0123, 16'hFFFF},
                 {16'h0000, 16'h0000, 16'hFFF0, 16'h0001}, 2'(s), "R7");
    // R8 shift-right add for each shift amount.
    for (int s = 0; s < 4; s++)
      send(3'd6, {16'h8000, 16'h7FFF, 16'hFFFF, 16'h0007},
                 {16'h8000, 16'h7FFF, 16'h0000, 16'h0001}, 2'(s), "R8");
    // R9 unassigned code.
    send(3'd7, {4{16'hFFFF}}, {4{16'h7FFF}}, 2'd3, "R9");
    idle(3);
    // R1 lane isolation: lane 0 saturates, others carry nothing across.
    send(3'd0, {16'h0001, 16'h0000, 16'hFFFF, 16'h7FFF},
               {16'h0000, 16'h0002, 16'h0001, 16'h7FFF}, 2'd0, "R1");
    send(3'd2, {16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF},
               {16'h0000, 16'h0001, 16'h0000, 16'h0001}, 2'd0, "R1");
    idle(2);
    // Random mix of all codes, with gaps to exercise R10 hold.
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      send(op, {$urandom(), $urandom()}, {$urandom(), $urandom()},
           2'($urandom_range(0, 3)), op_tag(op));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing results: actual=%0d pending expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule